// File: doc/BRIEF.md
# Tabular Q-Value Update Engine

This block updates one entry of a Q-table on every valid clock. The table has `NUM_STATES` rows and `NUM_ACTIONS` columns. An external policy and environment present the state just reached, the action chosen for it and the reward earned by the previous move. The block keeps the previous state and action in delay registers. In the same cycle it reads the full row of the new state, finds the largest value in that row, and writes the corrected estimate back to the cell of the previous state and action.

Each action column lives in its own memory bank, and only the addressed bank is written. The row maximum comes from a tree of comparators. The two scalings, by the learning rate and by the discount, are arithmetic right shifts. Both factors are therefore powers of two between 1/2^15 and 1, and each is supplied at run time as its shift count. The row of the state just reached is also presented to the policy, and any write made in that same cycle is already included in it.

Top module: `qlearn_engine`

## Requirements
- R1: After reset every table entry reads as zero on `q_row` and `upd_en` is low.
- R2: The first valid cycle after reset writes nothing (`upd_en` low). It only loads the delay registers with `next_state` and `action`.
- R3: On a later valid cycle the cell (previous state, previous action) is written with sat(Q + ((r + (M >>> gamma_sh)) − Q) >>> alpha_sh). Here Q is the old cell value, M is the maximum of the old row of `next_state`, r is `reward`, and `>>>` is an arithmetic shift. `upd_state`, `upd_action` and `upd_value` show that write.
- R4: A write changes exactly one cell. Every other entry of every bank keeps its value.
- R5: `max_q` equals the signed maximum of the row of `next_state` as it was before this cycle's write.
- R6: A cycle with `in_valid` low writes no cell and leaves the delay registers unchanged.
- R7: When `next_state` equals the previous state, `q_row` already shows the value being written in that cycle. The next update then starts from that fresh value.
- R8: The written value saturates to the signed range of `QW` bits (−32768..32767 at the default width).
- R9: With `alpha_sh` = 0 the cell is replaced by the saturated target r + (M >>> gamma_sh).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; clears the table |
| in_valid | input | 1 | Qualifies the state, action and reward of this cycle |
| next_state | input | log2(NUM_STATES) | State just reached; read address |
| action | input | log2(NUM_ACTIONS) | Action the policy chose for `next_state` |
| reward | input | QW | Signed reward of the previous move |
| alpha_sh | input | SHW | log2 of 1/alpha |
| gamma_sh | input | SHW | log2 of 1/gamma |
| q_row | output | NUM_ACTIONS*QW | Row of `next_state`, action 0 in the low bits, with this cycle's write included |
| max_q | output | QW | Maximum of the pre-write row of `next_state` |
| upd_en | output | 1 | A cell is written at the coming edge |
| upd_state | output | log2(NUM_STATES) | Row being written |
| upd_action | output | log2(NUM_ACTIONS) | Bank being written |
| upd_value | output | QW | Value being written |

## Verification
The checker takes for granted that `next_state` and `action` stay inside the table and that the shift counts stay below the internal width. At the default sizes every encoding of those inputs is legal. The stimulus uses only in-range states, actions and shift counts of 0 to 3. It also revisits states on purpose, so that reads and writes of the same row fall in the same cycle. Saturation is reached by driving large rewards repeatedly into one cell, and not by using out-of-range inputs.

// File: rtl/qle_pkg.sv
package qle_pkg;
    localparam int QLE_STATES  = 8;
    localparam int QLE_ACTIONS = 4;
    localparam int QLE_QW      = 16;
    localparam int QLE_SHW     = 4;
    // guard bits used by the update arithmetic
    localparam int QLE_GUARD   = 3;
endpackage

// File: rtl/qle_bank.sv
module qle_bank #(
    parameter int DEPTH = 8,
    parameter int W     = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [DEPTH-1:0][W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/qle_max_tree.sv
module qle_max_tree #(
    parameter int NIN = 4,
    parameter int W   = 16,
    localparam int LVLS   = $clog2(NIN),
    localparam int LEAVES = 1 << LVLS,
    localparam int NODES  = 2 * LEAVES - 1
) (
    input  logic [NIN-1:0][W-1:0] din,
    output logic [W-1:0]          dmax
);
    logic [W-1:0] node [NODES];

    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        if (i < NIN) begin : g_real
            assign node[LEAVES-1+i] = din[i];
        end else begin : g_pad
            // most negative value never wins
            assign node[LEAVES-1+i] = {1'b1, {(W-1){1'b0}}};
        end
    end

    for (genvar k = 0; k < LEAVES - 1; k++) begin : g_cmp
        assign node[k] = ($signed(node[2*k+1]) >= $signed(node[2*k+2]))
                         ? node[2*k+1] : node[2*k+2];
    end

    assign dmax = node[0];
endmodule

// File: rtl/qle_updater.sv
module qle_updater #(
    parameter int QW  = 16,
    parameter int SHW = 4,
    parameter int GB  = 3,
    localparam int EW = QW + GB
) (
    input  logic [QW-1:0]  q_old,
    input  logic [QW-1:0]  row_max,
    input  logic [QW-1:0]  reward,
    input  logic [SHW-1:0] alpha_sh,
    input  logic [SHW-1:0] gamma_sh,
    output logic [QW-1:0]  q_new
);
    localparam logic signed [EW-1:0] HI = {{(EW-QW+1){1'b0}}, {(QW-1){1'b1}}};
    localparam logic signed [EW-1:0] LO = {{(EW-QW+1){1'b1}}, {(QW-1){1'b0}}};

    logic signed [EW-1:0] ext_q, ext_m, ext_r;
    logic signed [EW-1:0] target, diff, sum;

    always_comb begin
        ext_q  = {{GB{q_old[QW-1]}},   q_old};
        ext_m  = {{GB{row_max[QW-1]}}, row_max};
        ext_r  = {{GB{reward[QW-1]}},  reward};
        // first shifter: discount applied to best next value
        target = ext_r + (ext_m >>> gamma_sh);
        diff   = target - ext_q;
        // second shifter: learning rate applied to the error
        sum    = ext_q + (diff >>> alpha_sh);
        if (sum > HI) begin
            q_new = HI[QW-1:0];
        end else if (sum < LO) begin
            q_new = LO[QW-1:0];
        end else begin
            q_new = sum[QW-1:0];
        end
    end
endmodule

// File: rtl/qlearn_engine.sv
module qlearn_engine
    import qle_pkg::*;
#(
    parameter int NUM_STATES  = QLE_STATES,
    parameter int NUM_ACTIONS = QLE_ACTIONS,
    parameter int QW          = QLE_QW,
    parameter int SHW         = QLE_SHW,
    localparam int SW         = $clog2(NUM_STATES),
    localparam int AW         = $clog2(NUM_ACTIONS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [SW-1:0]             next_state,
    input  logic [AW-1:0]             action,
    input  logic [QW-1:0]             reward,
    input  logic [SHW-1:0]            alpha_sh,
    input  logic [SHW-1:0]            gamma_sh,
    output logic [NUM_ACTIONS*QW-1:0] q_row,
    output logic [QW-1:0]             max_q,
    output logic                      upd_en,
    output logic [SW-1:0]             upd_state,
    output logic [AW-1:0]             upd_action,
    output logic [QW-1:0]             upd_value
);
    typedef logic [NUM_ACTIONS-1:0][QW-1:0] row_t;

    typedef struct packed {
        logic          primed;
        logic [SW-1:0] state;
        logic [AW-1:0] act;
        row_t          row;
    } pipe_t;

    pipe_t            st_d, st_q;
    row_t             rd_row;
    row_t             fwd_row;
    logic [NUM_ACTIONS-1:0] bank_we;
    logic [QW-1:0]    q_old;
    logic [QW-1:0]    q_new;

    for (genvar g = 0; g < NUM_ACTIONS; g++) begin : g_bank
        qle_bank #(.DEPTH(NUM_STATES), .W(QW)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bank_we[g]),
            .waddr (st_q.state),
            .wdata (q_new),
            .raddr (next_state),
            .rdata (rd_row[g])
        );
    end

    qle_max_tree #(.NIN(NUM_ACTIONS), .W(QW)) u_max (
        .din  (rd_row),
        .dmax (max_q)
    );

    qle_updater #(.QW(QW), .SHW(SHW), .GB(QLE_GUARD)) u_upd (
        .q_old    (q_old),
        .row_max  (max_q),
        .reward   (reward),
        .alpha_sh (alpha_sh),
        .gamma_sh (gamma_sh),
        .q_new    (q_new)
    );

    always_comb begin
        st_d   = st_q;
        upd_en = in_valid && st_q.primed;
        q_old  = st_q.row[st_q.act];
        for (int a = 0; a < NUM_ACTIONS; a++) begin
            bank_we[a] = upd_en && (st_q.act == AW'(a));
            fwd_row[a] = (bank_we[a] && (st_q.state == next_state))
                         ? q_new : rd_row[a];
        end
        if (in_valid) begin
            st_d.primed = 1'b1;
            st_d.state  = next_state;
            st_d.act    = action;
            st_d.row    = fwd_row;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_row      = fwd_row;
    assign upd_state  = st_q.state;
    assign upd_action = st_q.act;
    assign upd_value  = q_new;
endmodule

// File: rtl/qle_chk.sv
module qle_chk #(
    parameter int NA = 4,
    parameter int QW = 16,
    parameter int SW = 3,
    parameter int AW = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 upd_en,
    input logic [SW-1:0]        upd_state,
    input logic [AW-1:0]        upd_action,
    input logic [QW-1:0]        upd_value,
    input logic [SW-1:0]        next_state,
    input logic [NA*QW-1:0]     q_row,
    input logic [QW-1:0]        max_q,
    input logic [NA-1:0][QW-1:0] rd_row,
    input logic [NA-1:0]        bank_we
);
    // R4
    single_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_we));

    // R6
    write_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_we != '0) |-> (upd_en && in_valid));

    // R3
    stored_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(upd_en) && in_valid && next_state == $past(upd_state)
         && !(upd_en && upd_state == next_state && upd_action == $past(upd_action)))
        |-> q_row[int'($past(upd_action))*QW +: QW] == $past(upd_value));

    // R5
    always @(posedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NA; i++) begin
                row_max_bound_chk: assert ($signed(max_q) >= $signed(rd_row[i]));
            end
        end
    end
endmodule

bind qlearn_engine qle_chk #(
    .NA(NUM_ACTIONS), .QW(QW), .SW(SW), .AW(AW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .upd_en     (upd_en),
    .upd_state  (upd_state),
    .upd_action (upd_action),
    .upd_value  (upd_value),
    .next_state (next_state),
    .q_row      (q_row),
    .max_q      (max_q),
    .rd_row     (rd_row),
    .bank_we    (bank_we)
);

// File: tb/sim_qlearn_engine.sv
module sim_qlearn_engine;
    localparam int NS = 8;
    localparam int NA = 4;
    localparam int QW = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [2:0]        next_state = '0;
    logic [1:0]        action = '0;
    logic [15:0]       reward = '0;
    logic [3:0]        alpha_sh = '0;
    logic [3:0]        gamma_sh = '0;
    logic [NA*QW-1:0]  q_row;
    logic [15:0]       max_q;
    logic              upd_en;
    logic [2:0]        upd_state;
    logic [1:0]        upd_action;
    logic [15:0]       upd_value;

    always #5 clk = ~clk;

    qlearn_engine u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .next_state(next_state),
        .action(action), .reward(reward), .alpha_sh(alpha_sh), .gamma_sh(gamma_sh),
        .q_row(q_row), .max_q(max_q), .upd_en(upd_en), .upd_state(upd_state),
        .upd_action(upd_action), .upd_value(upd_value)
    );

    typedef struct packed {
        logic        vld;
        logic [2:0]  s;
        logic [1:0]  a;
        logic [15:0] r;
        logic [3:0]  ash;
        logic [3:0]  gsh;
    } vec_t;

    localparam vec_t VT [14] = '{
        '{1'b1, 3'd2, 2'd1, 16'd0,     4'd1, 4'd1},
        '{1'b1, 3'd5, 2'd3, 16'd100,   4'd1, 4'd1},
        '{1'b1, 3'd5, 2'd0, -16'sd40,  4'd2, 4'd0},
        '{1'b1, 3'd2, 2'd2, 16'd64,    4'd0, 4'd1},
        '{1'b0, 3'd7, 2'd3, 16'd999,   4'd0, 4'd0},
        '{1'b1, 3'd2, 2'd1, -16'sd200, 4'd3, 4'd2},
        '{1'b1, 3'd0, 2'd0, 16'd500,   4'd1, 4'd0},
        '{1'b1, 3'd2, 2'd1, 16'd300,   4'd2, 4'd1},
        '{1'b1, 3'd2, 2'd1, -16'sd50,  4'd0, 4'd3},
        '{1'b0, 3'd0, 2'd0, 16'd0,     4'd0, 4'd0},
        '{1'b1, 3'd6, 2'd3, 16'd1000,  4'd1, 4'd1},
        '{1'b1, 3'd6, 2'd3, 16'd1000,  4'd1, 4'd1},
        '{1'b1, 3'd3, 2'd0, -16'sd32000, 4'd0, 4'd0},
        '{1'b1, 3'd3, 2'd0, -16'sd32000, 4'd0, 4'd0}
    };

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    int refq [NS][NA];
    bit primed;
    int ps, pa;

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0d exp=%0d", req, got, exp);
        end
    endtask

    function automatic int satq(input int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int qr(input int i);
        return int'($signed(q_row[i*QW +: QW]));
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int s = 0; s < NS; s++)
            for (int a = 0; a < NA; a++) refq[s][a] = 0;
        primed = 0; ps = 0; pa = 0;
    endtask

    // drive one cycle, compare against the model, let the edge happen
    task automatic step(input bit v, input int s, input int a, input int r,
                        input int ash, input int gsh, output int wrote);
        int mx, newv;
        @(negedge clk);
        in_valid = v; next_state = 3'(s); action = 2'(a);
        reward = 16'(r); alpha_sh = 4'(ash); gamma_sh = 4'(gsh);
        #1;
        mx = refq[s][0];
        for (int i = 1; i < NA; i++) if (refq[s][i] > mx) mx = refq[s][i];
        chk("R5 max_q", int'($signed(max_q)), mx);
        chk("R2/R6 upd_en", int'(upd_en), int'(v && primed));
        wrote = 0;
        if (v && primed) begin
            newv = satq(refq[ps][pa] + ((r + (mx >>> gsh) - refq[ps][pa]) >>> ash));
            chk("R3 upd_value", int'($signed(upd_value)), newv);
            chk("R3 upd_state", int'(upd_state), ps);
            chk("R3 upd_action", int'(upd_action), pa);
            refq[ps][pa] = newv;
            wrote = newv;
        end
        for (int i = 0; i < NA; i++) chk("R4/R7 q_row", qr(i), refq[s][i]);
        if (v) begin primed = 1; ps = s; pa = a; end
    endtask

    initial begin
        int w;
        do_reset();
        // R1: table reads zero, no write
        for (int s = 0; s < NS; s++) begin
            @(negedge clk);
            next_state = 3'(s); in_valid = 1'b0; #1;
            for (int i = 0; i < NA; i++) chk("R1 reset row", qr(i), 0);
            chk("R1 upd_en", int'(upd_en), 0);
        end
        // vector table
        for (int k = 0; k < 14; k++)
            step(VT[k].vld, VT[k].s, VT[k].a, int'($signed(VT[k].r)),
                 VT[k].ash, VT[k].gsh, w);
        // R6: an idle sweep shows every row unchanged by idle cycles
        for (int s = 0; s < NS; s++) step(1'b0, s, 0, 12345, 0, 0, w);
        // R8: drive one cell past the positive limit
        do_reset();
        step(1'b1, 0, 0, 30000, 0, 0, w);
        step(1'b1, 0, 0, 30000, 0, 0, w);
        chk("R8 first", w, 30000);
        step(1'b1, 0, 0, 30000, 0, 0, w);
        chk("R8 saturated", w, 32767);
        // R9: alpha one replaces the cell by the target
        do_reset();
        step(1'b1, 4, 1, 0, 0, 0, w);
        step(1'b1, 1, 2, -700, 0, 1, w);
        chk("R9 replace", w, -700);
        step(1'b1, 4, 0, 50, 0, 1, w);
        chk("R9 replace with discount", w, 50);
        // R7: same-row revisit, then use of the fresh value
        step(1'b1, 4, 0, 80, 1, 0, w);
        step(1'b1, 4, 0, 80, 1, 0, w);
        @(negedge clk);
        in_valid = 1'b0;
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired got=0 exp=1");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule